// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is an I2C target that behaves like a small byte-addressed serial EEPROM of 2048 bytes. It watches SCL and SDA through a synchroniser clocked by a faster system clock. It pulls SDA low through an output enable, so an external pull-up gives the open-drain line. A control byte selects the device and one of eight 256-byte blocks. A word address byte then sets an 11-bit address pointer. Data bytes that follow are gathered in a page buffer.

The write that a STOP closes starts an internal write cycle of fixed length. During that cycle the device ignores its own address, so a master can poll it with control bytes until it acknowledges. The pointer is kept across transactions. This makes three kinds of read possible. A current-address read needs only a control byte. A random read first does a dummy write of the word address and then a repeated START. A sequential read continues for as long as the master acknowledges. A write-protect input keeps buffered data out of the array.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: Out of reset, and whenever no transfer addresses the device, `sda_oe` is low.
- R2: The device acknowledges a control byte only when bit 7 is 1, bits 6:4 equal `chip_sel_i` and no write cycle is running. In any other case it stays silent until the next START, and it acknowledges no further bytes of that transfer.
- R3: Control byte bits 3:1 give the block. Bit 0 is R/W, with 1 meaning read. The pointer of a write becomes {block, word address}. A byte written and closed by STOP reads back after the write cycle.
- R4: A write accepts any number of data bytes and acknowledges each one. Only the low 4 pointer bits advance, so bytes beyond a 16-byte page wrap to the page start, and a later byte to the same slot replaces an earlier one.
- R5: A STOP that ends a write carrying at least one data byte starts a write cycle of `WR_CYCLES` + 17 clocks. The device refuses its control byte for that time and acknowledges it afterwards.
- R6: A repeated START after data bytes aborts the write. No write cycle starts and the array keeps its old contents.
- R7: A read control byte sets the pointer's block bits from bits 3:1 and returns the byte at the pointer. The pointer is always one past the last byte written or read.
- R8: After a dummy write of the word address and a repeated START, a read control byte returns the byte at that address, most significant bit first.
- R9: Each master ACK in a read advances the full 11-bit pointer and sends the next byte. The pointer wraps from address 2047 to address 0.
- R10: The device releases SDA in the master's acknowledge bit, and it does not drive SDA after a NACK and STOP.
- R11: If `wp_i` is high while the write cycle commits, the array is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When high, pulls SDA low |
| wp_i | input | 1 | Write protect; high blocks array programming |
| chip_sel_i | input | 3 | Device select strap compared with control byte bits 6:4 |

## Verification
The bench probes ACK polling right after STOP and again well after the write cycle. A timer that never starts, or one that does not block the address, gives the wrong acknowledge on one of those two polls. A 20-byte page write from offset 12 checks the in-page wrap. A design that carries into the upper pointer bits would write the next page and read back stale data. A read that crosses address 2047 checks the full-pointer wrap. An aborted write followed by a delayed readback catches a device that keeps a pending write alive past a repeated START. A write under write-protect is read back to confirm that the array held its old value.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_RX    = 3'd1,
    PH_ACK   = 3'd2,
    PH_TX    = 3'd3,
    PH_TXACK = 3'd4
  } phase_t;

  typedef enum logic [1:0] {
    RL_CTRL  = 2'd0,
    RL_WADDR = 2'd1,
    RL_DATA  = 2'd2
  } role_t;

  localparam int CS_W   = 3;
  localparam int BLK_W  = 3;
  localparam int WORD_W = 8;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_s, sda_s;
  logic scl_prev_q, sda_prev_q;

  generate
    if (STAGES == 1) begin : g_one
      logic scl_q, sda_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= 1'b1;
          sda_q <= 1'b1;
        end else begin
          scl_q <= scl_i;
          sda_q <= sda_i;
        end
      end
      assign scl_s = scl_q;
      assign sda_s = sda_q;
    end else begin : g_chain
      logic [STAGES-1:0] scl_q, sda_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q <= '1;
          sda_q <= '1;
        end else begin
          scl_q <= {scl_q[STAGES-2:0], scl_i};
          sda_q <= {sda_q[STAGES-2:0], sda_i};
        end
      end
      assign scl_s = scl_q[STAGES-1];
      assign sda_s = sda_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign sda       = sda_s;
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
  parameter int WR_CYCLES = 400,
  parameter int PAGE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  output logic              busy,
  output logic              commit_stb,
  output logic [PAGE_W-1:0] commit_idx
);
  localparam int CW = $clog2(WR_CYCLES + 1);

  logic              run_q, run_n, cmt_q, cmt_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [PAGE_W-1:0] idx_q, idx_n;

  always_comb begin
    run_n = run_q;
    cmt_n = cmt_q;
    cnt_n = cnt_q;
    idx_n = idx_q;
    if (!run_q) begin
      if (kick) begin
        run_n = 1'b1;
        cnt_n = CW'(WR_CYCLES);
        idx_n = '0;
      end
    end else if (!cmt_q) begin
      if (cnt_q == '0) cmt_n = 1'b1;
      else             cnt_n = cnt_q - CW'(1);
    end else begin
      if (idx_q == '1) begin
        run_n = 1'b0;
        cmt_n = 1'b0;
      end else begin
        idx_n = idx_q + PAGE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cmt_q <= 1'b0;
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      run_q <= run_n;
      cmt_q <= cmt_n;
      cnt_q <= cnt_n;
      idx_q <= idx_n;
    end
  end

  assign busy       = run_q;
  assign commit_stb = cmt_q;
  assign commit_idx = idx_q;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= cells[raddr];
  end
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import eep_pkg::*;
#(
  parameter int PAGE_W      = 4,
  parameter int WR_CYCLES   = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  input  logic            wp_i,
  input  logic [CS_W-1:0] chip_sel_i
);
  localparam int AW   = BLK_W + WORD_W;
  localparam int PAGE = 1 << PAGE_W;
  localparam int HI_W = AW - PAGE_W;

  // line conditioning
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // protocol state
  phase_t           phase_q, phase_n;
  role_t            role_q, role_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [7:0]       sh_q, sh_n;
  logic [7:0]       tsh_q, tsh_n;
  logic [AW-1:0]    ptr_q, ptr_n;
  logic [BLK_W-1:0] blk_q, blk_n;
  logic             rd_q, rd_n;
  logic             oe_q, oe_n;
  logic             pend_q, pend_n;
  logic             wp_q;
  logic [PAGE-1:0]  pmask_q;
  logic [7:0]       pbuf_q [PAGE];

  logic             buf_we, mask_clr, kick;
  logic             busy, commit_stb, commit_we;
  logic [PAGE_W-1:0] commit_idx;
  logic [7:0]       rdata;
  logic             ctrl_match;

  assign ctrl_match = sh_q[7] && (sh_q[6:4] == chip_sel_i) && !busy;

  always_comb begin
    phase_n  = phase_q;
    role_n   = role_q;
    cnt_n    = cnt_q;
    sh_n     = sh_q;
    tsh_n    = tsh_q;
    ptr_n    = ptr_q;
    blk_n    = blk_q;
    rd_n     = rd_q;
    oe_n     = oe_q;
    pend_n   = pend_q;
    buf_we   = 1'b0;
    mask_clr = 1'b0;
    kick     = 1'b0;
    if (start_det) begin
      phase_n = PH_RX;
      role_n  = RL_CTRL;
      cnt_n   = '0;
      oe_n    = 1'b0;
      pend_n  = 1'b0;
    end else if (stop_det) begin
      phase_n = PH_IDLE;
      oe_n    = 1'b0;
      kick    = pend_q;
      pend_n  = 1'b0;
    end else begin
      unique case (phase_q)
        PH_RX: begin
          if (scl_rise) begin
            sh_n  = {sh_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            unique case (role_q)
              RL_CTRL: begin
                if (ctrl_match) begin
                  oe_n    = 1'b1;
                  phase_n = PH_ACK;
                  rd_n    = sh_q[0];
                  if (sh_q[0]) ptr_n = {sh_q[3:1], ptr_q[WORD_W-1:0]};
                  else         blk_n = sh_q[3:1];
                end else begin
                  phase_n = PH_IDLE;
                end
              end
              RL_WADDR: begin
                ptr_n    = {blk_q, sh_q};
                mask_clr = 1'b1;
                oe_n     = 1'b1;
                phase_n  = PH_ACK;
              end
              default: begin
                buf_we  = 1'b1;
                ptr_n   = {ptr_q[AW-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
                pend_n  = 1'b1;
                oe_n    = 1'b1;
                phase_n = PH_ACK;
              end
            endcase
          end
        end
        PH_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rd_q) begin
              tsh_n   = rdata;
              oe_n    = ~rdata[7];
              phase_n = PH_TX;
            end else begin
              oe_n    = 1'b0;
              phase_n = PH_RX;
              role_n  = (role_q == RL_CTRL) ? RL_WADDR : RL_DATA;
            end
          end
        end
        PH_TX: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              oe_n    = 1'b0;
              phase_n = PH_TXACK;
            end else begin
              oe_n = ~tsh_q[3'(4'd7 - cnt_q)];
            end
          end
        end
        PH_TXACK: begin
          if (scl_rise) begin
            ptr_n   = ptr_q + AW'(1);
            phase_n = sda_s ? PH_IDLE : PH_ACK;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      role_q  <= RL_CTRL;
      cnt_q   <= '0;
      sh_q    <= '0;
      tsh_q   <= '0;
      ptr_q   <= '0;
      blk_q   <= '0;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
      pend_q  <= 1'b0;
      wp_q    <= 1'b0;
    end else begin
      phase_q <= phase_n;
      role_q  <= role_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      tsh_q   <= tsh_n;
      ptr_q   <= ptr_n;
      blk_q   <= blk_n;
      rd_q    <= rd_n;
      oe_q    <= oe_n;
      pend_q  <= pend_n;
      wp_q    <= wp_i;
    end
  end

  // page buffer
  always_ff @(posedge clk) begin
    if (buf_we) pbuf_q[ptr_q[PAGE_W-1:0]] <= sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pmask_q <= '0;
    else if (mask_clr) pmask_q <= '0;
    else if (buf_we)   pmask_q[ptr_q[PAGE_W-1:0]] <= 1'b1;
  end

  // write cycle
  eep_wtimer #(.WR_CYCLES(WR_CYCLES), .PAGE_W(PAGE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(kick), .busy(busy),
    .commit_stb(commit_stb), .commit_idx(commit_idx)
  );

  assign commit_we = commit_stb && pmask_q[commit_idx] && !wp_q;

  eep_array #(.AW(AW), .DW(8)) u_array (
    .clk(clk), .rst_n(rst_n), .we(commit_we),
    .waddr({ptr_q[AW-1:PAGE_W], commit_idx}),
    .wdata(pbuf_q[commit_idx]),
    .raddr(ptr_q), .rdata(rdata)
  );

  assign sda_oe = oe_q;

  localparam int UNUSED_HI = HI_W;
endmodule

// File: rtl/i2c_eeprom_slave_chk.sv
module i2c_eeprom_slave_chk
  import eep_pkg::*;
#(
  parameter int AW     = 11,
  parameter int PAGE_W = 4
) (
  input logic          clk,
  input logic          rst_n,
  input phase_t        phase_q,
  input role_t         role_q,
  input logic          busy,
  input logic          stop_det,
  input logic          oe_q,
  input logic          commit_we,
  input logic          wp_i,
  input logic          buf_we,
  input logic [AW-1:0] ptr_q
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_BUSY_NO_CTRL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(phase_q == PH_ACK && role_q == RL_CTRL)); // R5

  AST_TIMER_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(busy)) |-> $past(stop_det)); // R5

  AST_COMMIT_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> busy); // R5

  AST_SDA_FREE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(stop_det)) |-> !oe_q); // R10

  AST_PAGE_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(buf_we)) |-> ptr_q[AW-1:PAGE_W] == $past(ptr_q[AW-1:PAGE_W])); // R4

  AST_WP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && commit_we) |-> !$past(wp_i)); // R11
endmodule

bind i2c_eeprom_slave i2c_eeprom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .phase_q(phase_q), .role_q(role_q),
  .busy(busy), .stop_det(stop_det), .oe_q(oe_q), .commit_we(commit_we),
  .wp_i(wp_i), .buf_we(buf_we), .ptr_q(ptr_q)
);

// File: tb/i2c_eeprom_slave_test.sv
module i2c_eeprom_slave_test;
  localparam int Q = 5;
  localparam int WAITC = 700;
  localparam logic [2:0] CHIP = 3'b101;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl_m, sda_m, wp;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] mem_m [2048];
  int ptr_m;

  i2c_eeprom_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wp_i(wp), .chip_sel_i(CHIP)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input bit b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic get_bit(output bit b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(input bit mack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    sda_m = !mack; wq(); scl_m = 1'b1; wq();
    chk(sda_oe == 1'b0, "R10 released in master ack bit", int'(sda_oe), 0);
    wq(); scl_m = 1'b0; wq();
  endtask

  function automatic logic [7:0] ctrl(input logic [2:0] blk, input bit rw);
    return {1'b1, CHIP, blk, rw};
  endfunction

  task automatic do_write(input logic [2:0] blk, input logic [7:0] wa,
                          input logic [7:0] data[$], input bit with_stop, input string rq);
    bit a;
    logic [7:0] stg [16];
    bit stgv [16];
    for (int i = 0; i < 16; i++) stgv[i] = 1'b0;
    bus_start();
    put_byte(ctrl(blk, 1'b0), a); chk(a, rq, int'(a), 1);
    put_byte(wa, a);              chk(a, rq, int'(a), 1);
    ptr_m = int'({blk, wa});
    foreach (data[k]) begin
      put_byte(data[k], a);
      chk(a, {rq, " data ack"}, int'(a), 1);
      stg[ptr_m % 16] = data[k];
      stgv[ptr_m % 16] = 1'b1;
      ptr_m = (ptr_m & ~15) | ((ptr_m + 1) & 15);
    end
    if (with_stop) begin
      bus_stop();
      if (!wp)
        for (int i = 0; i < 16; i++)
          if (stgv[i]) mem_m[(ptr_m & ~15) + i] = stg[i];
    end
  endtask

  task automatic do_read(input logic [2:0] blk, input bit random, input logic [7:0] wa,
                         input int n, input string rq);
    bit a;
    logic [7:0] v;
    if (random) begin
      bus_start();
      put_byte(ctrl(blk, 1'b0), a); chk(a, rq, int'(a), 1);
      put_byte(wa, a);              chk(a, rq, int'(a), 1);
      ptr_m = int'({blk, wa});
    end
    bus_start();
    put_byte(ctrl(blk, 1'b1), a); chk(a, {rq, " read ctrl"}, int'(a), 1);
    ptr_m = int'({blk, ptr_m[7:0]});
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, v);
      chk(v == mem_m[ptr_m], rq, int'(v), int'(mem_m[ptr_m]));
      ptr_m = (ptr_m + 1) % 2048;
    end
    bus_stop();
  endtask

  task automatic poll(input bit expect_ack, input string rq);
    bit a;
    bus_start();
    put_byte(ctrl(3'd0, 1'b0), a);
    chk(a == expect_ack, rq, int'(a), int'(expect_ack));
    bus_stop();
  endtask

  task automatic idle_wait();
    repeat (WAITC) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] dq[$];
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    chk(sda_oe == 1'b0, "R1 in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    chk(sda_oe == 1'b0, "R1 after reset", int'(sda_oe), 0);

    // R2: wrong chip select, then a further byte of the same transfer
    bus_start();
    put_byte({1'b1, 3'b010, 3'b000, 1'b0}, a);
    chk(!a, "R2 chip mismatch", int'(a), 0);
    put_byte(8'h00, a);
    chk(!a, "R2 rest of transfer ignored", int'(a), 0);
    bus_stop();
    // R2: tag bit 7 clear
    bus_start();
    put_byte({1'b0, CHIP, 3'b000, 1'b0}, a);
    chk(!a, "R2 tag bit clear", int'(a), 0);
    bus_stop();

    // R3 byte write, R5 polling, R8 random read
    dq = {8'hA7};
    do_write(3'd2, 8'h35, dq, 1'b1, "R3 byte write");
    poll(1'b0, "R5 busy refuses address");
    idle_wait();
    poll(1'b1, "R5 ack after write cycle");
    do_read(3'd2, 1'b1, 8'h35, 1, "R8 random read");

    // R4 page write wrapping within the page
    dq = {};
    for (int i = 0; i < 20; i++) dq.push_back(8'(8'h40 + i));
    do_write(3'd5, 8'h7C, dq, 1'b1, "R4 page write");
    poll(1'b0, "R5 busy after page write");
    idle_wait();
    do_read(3'd5, 1'b0, 8'h00, 1, "R7 current read after page write");
    do_read(3'd5, 1'b1, 8'h70, 15, "R9 sequential read in page");
    do_read(3'd5, 1'b0, 8'h00, 1, "R7 current read after read");

    // R9 wrap from the top of the array
    dq = {8'h5A};
    do_write(3'd7, 8'hFF, dq, 1'b1, "R9 write top");
    idle_wait();
    dq = {8'hC3};
    do_write(3'd0, 8'h00, dq, 1'b1, "R9 write bottom");
    idle_wait();
    do_read(3'd7, 1'b1, 8'hFF, 2, "R9 wrap 2047 to 0");

    // R6 abort by repeated START
    dq = {8'h11};
    do_write(3'd2, 8'h35, dq, 1'b0, "R6 aborted write");
    do_read(3'd2, 1'b1, 8'h35, 1, "R6 no change right away");
    idle_wait();
    do_read(3'd2, 1'b1, 8'h35, 1, "R6 no change later");

    // R11 write protect
    wp = 1'b1;
    dq = {8'h22};
    do_write(3'd2, 8'h35, dq, 1'b1, "R11 protected write");
    idle_wait();
    wp = 1'b0;
    do_read(3'd2, 1'b1, 8'h35, 1, "R11 array unchanged");

    // R10 quiet bus after NACK and STOP
    for (int i = 0; i < 4; i++) begin
      repeat (10) @(posedge clk);
      #1;
      chk(sda_oe == 1'b0, "R10 quiet after stop", int'(sda_oe), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule